// File: doc/BRIEF.md
# Physical memory protection checker

This block decides, for each memory access of a 32-bit core, whether the access may proceed. It holds no configuration of its own. Sixteen protection regions are presented to it as flat vectors: one configuration byte and one 32-bit address word per region. The address word holds bits 33 down to 2 of a physical byte address. Each request carries a byte address, an access type and a privilege level. The block evaluates all regions in parallel and lets the lowest-numbered matching region decide. One clock later it returns a registered verdict that also reports whether any region matched and which one.

Each region picks one of four address modes.

- Off: the region never matches.
- Top-of-range: the region spans from the previous region's raw address word, inclusive, up to its own address word, exclusive.
- Four-byte: the region covers one naturally aligned word.
- Power-of-two: the run of trailing ones in the address word sets a naturally aligned size of at least 8 bytes.

A region whose lock bit is clear restricts only user and supervisor code. A locked region applies its permissions to machine code as well. An access that matches no region is allowed only in machine mode.

Top module: `pmp_checker`

## Requirements
- R1: `rsp_valid_o` is high in exactly the cycle after a cycle with `req_valid_i` high. In a cycle where `rsp_valid_o` is low, `rsp_deny_o`, `rsp_match_o` and `rsp_region_o` are all zero.
- R2: Region n uses config byte `region_cfg_i[8n+7:8n]`, with R in bit 0, W in bit 1, X in bit 2, mode in bits [4:3] and lock in bit 7. It uses address word `region_addr_i[32n+31:32n]`. With mode 2 (four-byte), the region matches byte addresses A where A[31:2] equals the address word.
- R3: With mode 3 (power-of-two), let k be the index of the lowest zero bit of the address word. The region covers 2^(k+3) bytes, aligned to that size, and the minimum size is 8 bytes.
- R4: With mode 1 (top-of-range), region n matches when the previous word (raw address word of region n-1) is at most A[31:2], and A[31:2] is below its own word. The previous word is taken raw even when region n-1 is off or power-of-two. Region 0 uses 0 as its bottom.
- R5: A region with mode 0 (off) never matches.
- R6: When several regions match, the lowest index is reported and its permissions decide.
- R7: Access type is encoded 0 = read, 1 = write and 2 = execute. Privilege is encoded 0 = user, 1 = supervisor and 3 = machine. A matched unlocked region allows every machine access. For user and supervisor accesses it allows an access only when the permission bit for that access type is set.
- R8: A matched locked region enforces its permission bits on machine accesses too.
- R9: When no region matches, `rsp_match_o` is 0 and `rsp_region_o` is 0. The access is allowed for machine privilege and denied otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| region_cfg_i | input | 128 | Config bytes, region n at bits [8n+7:8n] |
| region_addr_i | input | 512 | Address words, region n at bits [32n+31:32n] |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 32 | Request byte address |
| req_type_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| req_priv_i | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| rsp_valid_o | output | 1 | Verdict valid, one cycle after the request |
| rsp_deny_o | output | 1 | Access denied |
| rsp_match_o | output | 1 | Some region matched |
| rsp_region_o | output | 4 | Index of the deciding region |

## Verification
A wrong mode decode or comparator bound appears on the very next response cycle as the wrong region index or as a missing match. The bench therefore probes addresses one word inside and one word outside every region edge. A fault in priority ordering or lock handling appears only when overlapping regions or machine-mode requests hit the faulty entry. The stimulus places a permissive region behind a restrictive one and sends machine requests to both locked and unlocked regions. The response is a single register stage, so every fault shows up exactly one cycle after the request that exposes it.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  localparam int unsigned NUM_REGIONS = 16;
  localparam int unsigned CFG_W       = 8;
  localparam int unsigned ADDR_W      = 32;

  localparam int unsigned CFG_R_BIT    = 0;
  localparam int unsigned CFG_W_BIT    = 1;
  localparam int unsigned CFG_X_BIT    = 2;
  localparam int unsigned CFG_MODE_LSB = 3;
  localparam int unsigned CFG_LOCK_BIT = 7;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } pmp_mode_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } pmp_acc_e;

  localparam logic [1:0] PRIV_M = 2'd3;
endpackage

// File: rtl/pmp_region_match.sv
module pmp_region_match
  import pmp_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] top_i,
  input  logic [AW-1:0] word_i,
  output logic          hit_o
);
  logic [AW-1:0] napot_mask;
  logic          tor_hit, na4_hit, napot_hit;

  // trailing ones plus the lowest zero form the don't-care bits
  assign napot_mask = top_i ^ (top_i + 1'b1);

  assign tor_hit   = (word_i >= base_i) && (word_i < top_i);
  assign na4_hit   = (word_i == top_i);
  assign napot_hit = ((word_i ^ top_i) & ~napot_mask) == '0;

  always_comb begin
    unique case (pmp_mode_e'(mode_i))
      MODE_TOR:   hit_o = tor_hit;
      MODE_NA4:   hit_o = na4_hit;
      MODE_NAPOT: hit_o = napot_hit;
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmp_perm_eval.sv
module pmp_perm_eval
  import pmp_pkg::*;
(
  input  logic       perm_r_i,
  input  logic       perm_w_i,
  input  logic       perm_x_i,
  input  logic       lock_i,
  input  logic [1:0] acc_type_i,
  input  logic [1:0] priv_i,
  output logic       allow_o
);
  logic bit_ok;

  always_comb begin
    unique case (pmp_acc_e'(acc_type_i))
      ACC_READ:  bit_ok = perm_r_i;
      ACC_WRITE: bit_ok = perm_w_i;
      ACC_EXEC:  bit_ok = perm_x_i;
      default:   bit_ok = 1'b0;
    endcase
  end

  assign allow_o = ((priv_i == PRIV_M) && !lock_i) || bit_ok;
endmodule

// File: rtl/pmp_prio_sel.sv
module pmp_prio_sel #(
  parameter int unsigned N    = 16,
  localparam int unsigned IW  = $clog2(N)
) (
  input  logic [N-1:0]  hit_i,
  input  logic [N-1:0]  allow_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic          allow_o
);
  always_comb begin
    any_o   = 1'b0;
    idx_o   = '0;
    allow_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o   = 1'b1;
        idx_o   = IW'(i);
        allow_o = allow_i[i];
      end
    end
  end
endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = pmp_pkg::NUM_REGIONS,
  parameter int unsigned AW          = pmp_pkg::ADDR_W,
  parameter int unsigned XLEN        = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_REGIONS*CFG_W-1:0]   region_cfg_i,
  input  logic [NUM_REGIONS*AW-1:0]      region_addr_i,
  input  logic                           req_valid_i,
  input  logic [XLEN-1:0]                req_addr_i,
  input  logic [1:0]                     req_type_i,
  input  logic [1:0]                     req_priv_i,
  output logic                           rsp_valid_o,
  output logic                           rsp_deny_o,
  output logic                           rsp_match_o,
  output logic [$clog2(NUM_REGIONS)-1:0] rsp_region_o
);
  localparam int unsigned IW  = $clog2(NUM_REGIONS);
  localparam int unsigned PAD = AW - XLEN + 2;

  logic [AW-1:0]          req_word;
  logic [NUM_REGIONS-1:0] hit_v, allow_v;
  logic                   any_hit, sel_allow, final_allow;
  logic [IW-1:0]          sel_idx;
  logic [CFG_W-1:0]       cfg_a [NUM_REGIONS];
  logic [AW-1:0]          addr_a[NUM_REGIONS];
  logic [NUM_REGIONS-1:0] unused_cfg_bits;
  logic [1:0]             unused_addr_lsb;

  assign req_word        = {{PAD{1'b0}}, req_addr_i[XLEN-1:2]};
  assign unused_addr_lsb = req_addr_i[1:0];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic [AW-1:0] base;

    assign cfg_a[g]  = region_cfg_i[g*CFG_W +: CFG_W];
    assign addr_a[g] = region_addr_i[g*AW +: AW];
    assign unused_cfg_bits[g] = ^cfg_a[g][6:5];

    if (g == 0) begin : g_first
      assign base = '0;
    end else begin : g_rest
      assign base = addr_a[g-1];
    end

    pmp_region_match #(.AW(AW)) u_match (
      .mode_i (cfg_a[g][CFG_MODE_LSB +: 2]),
      .base_i (base),
      .top_i  (addr_a[g]),
      .word_i (req_word),
      .hit_o  (hit_v[g])
    );

    pmp_perm_eval u_perm (
      .perm_r_i   (cfg_a[g][CFG_R_BIT]),
      .perm_w_i   (cfg_a[g][CFG_W_BIT]),
      .perm_x_i   (cfg_a[g][CFG_X_BIT]),
      .lock_i     (cfg_a[g][CFG_LOCK_BIT]),
      .acc_type_i (req_type_i),
      .priv_i     (req_priv_i),
      .allow_o    (allow_v[g])
    );
  end

  pmp_prio_sel #(.N(NUM_REGIONS)) u_sel (
    .hit_i   (hit_v),
    .allow_i (allow_v),
    .any_o   (any_hit),
    .idx_o   (sel_idx),
    .allow_o (sel_allow)
  );

  assign final_allow = any_hit ? sel_allow : (req_priv_i == PRIV_M);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_deny_o   <= 1'b0;
      rsp_match_o  <= 1'b0;
      rsp_region_o <= '0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      rsp_deny_o   <= req_valid_i && !final_allow;
      rsp_match_o  <= req_valid_i && any_hit;
      rsp_region_o <= req_valid_i ? sel_idx : '0;
    end
  end
endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva
  import pmp_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 16
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [NUM_REGIONS*CFG_W-1:0]   region_cfg_i,
  input logic                           req_valid_i,
  input logic [1:0]                     req_priv_i,
  input logic                           rsp_valid_o,
  input logic                           rsp_deny_o,
  input logic                           rsp_match_o,
  input logic [$clog2(NUM_REGIONS)-1:0] rsp_region_o
);
  logic [NUM_REGIONS-1:0] lock_q, off_q;
  logic                   priv_m_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q   <= '0;
      off_q    <= '0;
      priv_m_q <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        lock_q[i] <= region_cfg_i[i*CFG_W + CFG_LOCK_BIT];
        off_q[i]  <= region_cfg_i[i*CFG_W + CFG_MODE_LSB +: 2] == MODE_OFF;
      end
      priv_m_q <= req_priv_i == PRIV_M;
    end
  end

  assert_rsp_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_rsp_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_deny_o && !rsp_match_o));

  assert_off_never_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_match_o |-> !off_q[rsp_region_o]);

  assert_unlocked_machine_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_match_o && priv_m_q && !lock_q[rsp_region_o]) |-> !rsp_deny_o);

  assert_nomatch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_match_o) |-> (rsp_deny_o == !priv_m_q));
endmodule

bind pmp_checker pmp_checker_sva #(.NUM_REGIONS(NUM_REGIONS)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .region_cfg_i (region_cfg_i),
  .req_valid_i  (req_valid_i),
  .req_priv_i   (req_priv_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_deny_o   (rsp_deny_o),
  .rsp_match_o  (rsp_match_o),
  .rsp_region_o (rsp_region_o)
);

// File: tb/sim_pmp_checker.sv
`timescale 1ns/1ps
module sim_pmp_checker;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   cfg_a [16];
  logic [31:0]  adr_a [16];
  logic [127:0] cfg_flat;
  logic [511:0] adr_flat;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [1:0]   req_type = '0, req_priv = '0;
  logic         rsp_valid, rsp_deny, rsp_match;
  logic [3:0]   rsp_region;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;
  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 16; i++) begin
      cfg_flat[i*8 +: 8]   = cfg_a[i];
      adr_flat[i*32 +: 32] = adr_a[i];
    end
  end

  pmp_checker u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .region_cfg_i(cfg_flat), .region_addr_i(adr_flat),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_type_i(req_type), .req_priv_i(req_priv),
    .rsp_valid_o(rsp_valid), .rsp_deny_o(rsp_deny),
    .rsp_match_o(rsp_match), .rsp_region_o(rsp_region)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one request per call, expected {deny, match, region}
  task automatic send(input logic [31:0] a, input logic [1:0] t, input logic [1:0] p,
                      input logic d, input logic m, input logic [3:0] r, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_type  = t;
    req_priv  = p;
    exp_q.push_back({d, m, r});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected response", 32'd1, 32'd0);
      end else begin
        logic [5:0] e;
        string      tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(tg, {26'd0, rsp_deny, rsp_match, rsp_region}, {26'd0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      cfg_a[i] = 8'h00;
      adr_a[i] = 32'h0;
    end
    cfg_a[0] = 8'h11; adr_a[0] = 32'h0000_0400; // NA4 0x1000, R
    cfg_a[1] = 8'h00; adr_a[1] = 32'h0000_0800; // OFF, base for region 2
    cfg_a[2] = 8'h0B; adr_a[2] = 32'h0000_0C00; // TOR 0x2000..0x2FFF, RW
    cfg_a[3] = 8'h9C; adr_a[3] = 32'h0000_1003; // NAPOT 0x4000..0x401F, X, locked
    cfg_a[4] = 8'h17; adr_a[4] = 32'h0000_0400; // NA4 0x1000, RWX (shadowed)
    cfg_a[5] = 8'h1B; adr_a[5] = 32'h0000_1800; // NAPOT 8 bytes at 0x6000, RW
    cfg_a[6] = 8'h89; adr_a[6] = 32'h0000_1C00; // TOR 0x6000..0x6FFF, R, locked

    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 reset deny",  {31'd0, rsp_deny},  32'd0);
    rst_n = 1'b1;

    send(32'h1000, RD, PU, 0, 1, 0, "R2 na4 first byte");
    send(32'h1003, RD, PU, 0, 1, 0, "R2 na4 last byte");
    send(32'h1004, RD, PU, 1, 0, 0, "R2 na4 past end");
    send(32'h1000, WR, PU, 1, 1, 0, "R6 lowest index wins");
    send(32'h2000, RD, PU, 0, 1, 2, "R5 off region skipped R4 base");
    send(32'h2FFC, WR, PU, 0, 1, 2, "R4 tor last word");
    send(32'h3000, RD, PU, 1, 0, 0, "R4 tor top exclusive");
    send(32'h1FFC, RD, PU, 1, 0, 0, "R4 tor below base");
    send(32'h4000, EX, PU, 0, 1, 3, "R3 napot first");
    send(32'h401C, EX, PU, 0, 1, 3, "R3 napot last");
    send(32'h4020, EX, PU, 1, 0, 0, "R3 napot past end");
    send(32'h4010, RD, PU, 1, 1, 3, "R3 napot perm");
    send(32'h4010, RD, PM, 1, 1, 3, "R8 locked machine read");
    send(32'h4004, EX, PM, 0, 1, 3, "R8 locked machine exec");
    send(32'h1000, WR, PM, 0, 1, 0, "R7 unlocked machine write");
    send(32'h1000, WR, PS, 1, 1, 0, "R7 supervisor write");
    send(32'h6004, WR, PU, 0, 1, 5, "R3 napot min size");
    send(32'h6008, WR, PU, 1, 1, 6, "R3 napot min end");
    send(32'h6008, RD, PU, 0, 1, 6, "R4 tor over napot base");
    send(32'h5FFC, RD, PU, 1, 0, 0, "R4 tor below napot base");
    send(32'h6100, WR, PM, 1, 1, 6, "R8 locked tor machine write");
    send(32'h6100, RD, PM, 0, 1, 6, "R8 locked tor machine read");
    send(32'h8000, WR, PM, 0, 0, 0, "R9 machine no match");
    send(32'h8000, RD, PS, 1, 0, 0, "R9 supervisor no match");
    idle(2);
    check("R1 idle valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 idle match", {31'd0, rsp_match}, 32'd0);
    check("R1 idle deny",  {31'd0, rsp_deny},  32'd0);

    cfg_a[0] = 8'h09; adr_a[0] = 32'h0000_0100; // TOR 0x0..0x3FF, R
    send(32'h0000, RD, PU, 0, 1, 0, "R4 region0 bottom zero");
    send(32'h03FC, RD, PU, 0, 1, 0, "R4 region0 last word");
    send(32'h0400, RD, PU, 1, 0, 0, "R4 region0 top");
    send(32'h0000, WR, PU, 1, 1, 0, "R7 region0 no write");
    idle(3);
    check("R1 queue drained", exp_q.size(), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule